// File: doc/BRIEF.md
# Two-Stage Byte-Loaded Angle Register

This block builds a 16-bit binary angle from bus writes and passes it on to conversion logic that must never see a half-updated value. Two byte stages gather the word. The upper stage takes the most significant byte and the lower stage takes the least significant byte. A third stage, the transfer stage, copies the combined word to the output. Software on an 8-bit bus puts the same byte on both bus halves and pulses one byte enable per write. It then pulses the transfer enable, which gives double buffering. On a 16-bit bus, all three enables can be pulsed together.

Each stage works like a level-sensitive latch timed by the system clock. While its enable is high, the stage passes its input straight through. While the enable is low, the stage keeps its value. The transfer stage sees the byte stages' pass-through values in the same cycle, so a word on the bus reaches the output one clock after it is sampled. A parameter can mark any enable as unused. That stage then stays open permanently, as if the pin were pulled high.

The bus timing rules are converted from nanoseconds to clock cycles. A setup or pulse-width violation sets a sticky error output. When the held angle changes, a one-cycle strobe goes out so that the converter can resample. The control pins are plain levels. The block has no valid/ready handshake and applies no back-pressure, because a stage can always accept its input.

Top module: `angle_latch`

## Requirements
- R1: While reset is sampled low at a clock edge, both byte stages, the output angle, the update strobe and the error flag all become zero (angle zero means 0 degrees).
- R2: The upper enable loads `bus_data[15:8]` into the most significant byte of the word, and bit 15 is the angle MSB. The lower enable loads `bus_data[7:0]` into the least significant byte. The code is natural binary.
- R3: A byte stage whose enable is low ignores its bus half. Later transfers bring out the value it held.
- R4: The output angle changes only at an edge where the transfer enable was sampled high. It then takes {upper view, lower view}, where a view is the bus half if that stage's enable is high in the same cycle and the stored byte otherwise. In every other cycle the angle holds.
- R5: Bytes loaded while the transfer enable is low do not reach the output until the next transfer.
- R6: When an enable is parameterised as unused, its pin is ignored and its stage is always open. With all three unused, the angle equals the bus word sampled one edge earlier, and no timing checks apply to those stages.
- R7: `angle_upd` is high for exactly the cycles in which `angle_out` differs from its value in the previous cycle. A transfer that loads an unchanged word gives no strobe.
- R8: A setup violation is a byte enable's rising edge (sampled high after being sampled low) in cycle t when that byte's bus half changed in any of cycles t-SETUP+1..t. A change here means a value that differs from the previous cycle's sample. SETUP is 13 cycles at the defaults (50 ns, 4 ns clock).
- R9: A pulse-width violation is any used enable falling after being sampled high for fewer than PULSE consecutive cycles. PULSE is 25 cycles at the defaults (100 ns).
- R10: `timing_err` goes high at the edge that ends a violating cycle. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 16 | Data bus; upper half feeds the MSB stage and lower half feeds the LSB stage |
| hi_load | input | 1 | Upper byte stage open while high |
| lo_load | input | 1 | Lower byte stage open while high |
| xfer_load | input | 1 | Transfer stage open while high |
| angle_out | output | 16 | Held angle word |
| angle_upd | output | 1 | One-cycle strobe when angle_out changes |
| timing_err | output | 1 | Sticky setup or pulse-width violation flag |

## Verification
The angle and its strobe are due one edge after the cycle in which the transfer enable is sampled high, and they arrive together. The error flag is due one edge after the cycle that holds the offending enable edge. The bench drives inputs and compares every output on falling clock edges. On rising edges it advances a behavioural model, so each comparison covers exactly one register delay.

// File: rtl/angle_latch_pkg.sv
package angle_latch_pkg;
  // Round a time in ns up to whole clock cycles of the given period in ps.
  function automatic int ns_to_cycles(input int ns, input int period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/angle_byte_stage.sv
module angle_byte_stage #(
  parameter int W    = 8,
  parameter bit USED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] view
);
  localparam logic FORCE_OPEN = !USED;

  logic         open_w;
  logic [W-1:0] held_q;

  assign open_w = en | FORCE_OPEN;
  assign view   = open_w ? d : held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= view;
  end
endmodule

// File: rtl/angle_xfer_stage.sv
module angle_xfer_stage #(
  parameter int W    = 16,
  parameter bit USED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         upd
);
  localparam logic FORCE_OPEN = !USED;

  logic open_w;
  assign open_w = en | FORCE_OPEN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= '0;
      upd <= 1'b0;
    end else begin
      upd <= open_w && (d != q);
      if (open_w) q <= d;
    end
  end
endmodule

// File: rtl/angle_edge_monitor.sv
module angle_edge_monitor #(
  parameter int W           = 8,
  parameter int SETUP_CYC   = 13,
  parameter int PULSE_CYC   = 25,
  parameter bit CHECK_SETUP = 1'b1,
  parameter bit ACTIVE      = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic         viol
);
  localparam int TOP = angle_latch_pkg::max_of(SETUP_CYC, PULSE_CYC);
  localparam int CW  = $clog2(TOP + 1);
  localparam logic [CW-1:0] SAT  = CW'(TOP);
  localparam logic [CW-1:0] SMIN = CW'(SETUP_CYC);
  localparam logic [CW-1:0] PMIN = CW'(PULSE_CYC);

  logic [W-1:0]  d_q;
  logic          en_q;
  logic [CW-1:0] quiet_q, quiet_now, width_q;
  logic          changed, rise, fall, setup_bad, pulse_bad;

  assign changed   = (d != d_q);
  assign quiet_now = changed ? '0 : ((quiet_q == SAT) ? quiet_q : quiet_q + 1'b1);
  assign rise      = en && !en_q;
  assign fall      = !en && en_q;
  assign setup_bad = CHECK_SETUP && rise && (quiet_now < SMIN);
  assign pulse_bad = fall && (width_q < PMIN);
  assign viol      = ACTIVE && (setup_bad || pulse_bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_q     <= '0;
      en_q    <= 1'b1;
      quiet_q <= SAT;
      width_q <= SAT;
    end else begin
      d_q     <= d;
      en_q    <= en;
      quiet_q <= quiet_now;
      if (!en)               width_q <= '0;
      else if (width_q != SAT) width_q <= width_q + 1'b1;
    end
  end
endmodule

// File: rtl/angle_latch.sv
module angle_latch #(
  parameter int BYTE_W        = 8,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int SETUP_NS      = 50,
  parameter int PULSE_NS      = 100,
  parameter bit HI_EN_USED    = 1'b1,
  parameter bit LO_EN_USED    = 1'b1,
  parameter bit XFER_EN_USED  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*BYTE_W-1:0]   bus_data,
  input  logic                  hi_load,
  input  logic                  lo_load,
  input  logic                  xfer_load,
  output logic [2*BYTE_W-1:0]   angle_out,
  output logic                  angle_upd,
  output logic                  timing_err
);
  localparam int WORD_W    = 2 * BYTE_W;
  localparam int SETUP_CYC = angle_latch_pkg::ns_to_cycles(SETUP_NS, CLK_PERIOD_PS);
  localparam int PULSE_CYC = angle_latch_pkg::ns_to_cycles(PULSE_NS, CLK_PERIOD_PS);
  localparam bit [1:0] LANE_USED = {HI_EN_USED, LO_EN_USED};

  logic [1:0]        lane_en;
  logic [BYTE_W-1:0] lane_view [2];
  logic [2:0]        viol;
  logic [WORD_W-1:0] word_view;

  assign lane_en = {hi_load, lo_load};

  // Lane 1 carries the most significant byte, lane 0 the least.
  for (genvar g = 0; g < 2; g++) begin : g_lane
    angle_byte_stage #(.W(BYTE_W), .USED(LANE_USED[g])) u_stage (
      .clk(clk), .rst_n(rst_n), .en(lane_en[g]),
      .d(bus_data[g*BYTE_W +: BYTE_W]), .view(lane_view[g])
    );
    angle_edge_monitor #(
      .W(BYTE_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
      .CHECK_SETUP(1'b1), .ACTIVE(LANE_USED[g])
    ) u_mon (
      .clk(clk), .rst_n(rst_n), .en(lane_en[g]),
      .d(bus_data[g*BYTE_W +: BYTE_W]), .viol(viol[g])
    );
  end

  assign word_view = {lane_view[1], lane_view[0]};

  angle_xfer_stage #(.W(WORD_W), .USED(XFER_EN_USED)) u_xfer (
    .clk(clk), .rst_n(rst_n), .en(xfer_load), .d(word_view),
    .q(angle_out), .upd(angle_upd)
  );

  angle_edge_monitor #(
    .W(WORD_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .CHECK_SETUP(1'b0), .ACTIVE(XFER_EN_USED)
  ) u_xfer_mon (
    .clk(clk), .rst_n(rst_n), .en(xfer_load), .d(word_view), .viol(viol[2])
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    timing_err <= 1'b0;
    else if (|viol) timing_err <= 1'b1;
  end
endmodule

// File: rtl/angle_latch_chk.sv
module angle_latch_chk #(
  parameter int WORD_W       = 16,
  parameter bit XFER_EN_USED = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_load,
  input logic [WORD_W-1:0] angle_out,
  input logic              angle_upd,
  input logic              timing_err
);
  localparam logic XFER_OPEN = !XFER_EN_USED;

  // R1: reset clears the visible state
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (angle_out == '0 && !angle_upd && !timing_err));

  // R4: with the transfer stage closed the angle holds
  p_hold_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !(xfer_load || XFER_OPEN)) |=> $stable(angle_out));

  // R7: strobe marks a real change
  p_upd_means_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (angle_upd && $past(rst_n)) |-> (angle_out != $past(angle_out)));

  // R7: every change is strobed
  p_change_means_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(angle_out) && $past(rst_n)) |-> angle_upd);

  // R7: strobe only follows an open transfer stage
  p_upd_needs_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (angle_upd && $past(rst_n)) |-> $past(xfer_load || XFER_OPEN));

  // R10: error flag is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |=> timing_err);
endmodule

bind angle_latch angle_latch_chk #(.WORD_W(2*BYTE_W), .XFER_EN_USED(XFER_EN_USED)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_load(xfer_load),
  .angle_out(angle_out), .angle_upd(angle_upd), .timing_err(timing_err)
);

// File: tb/angle_latch_test.sv
`timescale 1ns/1ps
module angle_latch_test;
  localparam int SETUP = 13;
  localparam int PULSE = 25;
  localparam int BIG   = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_data = '0;
  logic        hi_load = 1'b0, lo_load = 1'b0, xfer_load = 1'b0;
  logic [15:0] angle_out, angle_o;
  logic        angle_upd, timing_err, upd_o, err_o;

  int tests = 0, fails = 0;
  bit cmp_on = 1'b0;
  string phase = "R1";

  always #2 clk = ~clk;

  angle_latch uut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .hi_load(hi_load),
    .lo_load(lo_load), .xfer_load(xfer_load), .angle_out(angle_out),
    .angle_upd(angle_upd), .timing_err(timing_err)
  );

  // R6: every enable declared unused; pins tied low must not matter
  angle_latch #(.HI_EN_USED(1'b0), .LO_EN_USED(1'b0), .XFER_EN_USED(1'b0)) uut_open (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .hi_load(1'b0),
    .lo_load(1'b0), .xfer_load(1'b0), .angle_out(angle_o),
    .angle_upd(upd_o), .timing_err(err_o)
  );

  // Behavioural reference model
  logic [7:0]  m_hi, m_lo, pd [2];
  logic [15:0] m_ang, o_ang;
  logic        m_upd, m_err, o_upd;
  int          quiet [2];
  int          width [3];
  logic        pe [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_ang = 0; m_upd = 0; m_err = 0; o_ang = 0; o_upd = 0;
      for (int i = 0; i < 2; i++) begin pd[i] = 0; quiet[i] = BIG; end
      for (int i = 0; i < 3; i++) begin pe[i] = 1; width[i] = BIG; end
    end else begin
      logic [7:0] vh, vl, half;
      logic [15:0] nw;
      logic en [3];
      bit bad;
      en[0] = lo_load; en[1] = hi_load; en[2] = xfer_load;
      vh = hi_load ? bus_data[15:8] : m_hi;
      vl = lo_load ? bus_data[7:0]  : m_lo;
      nw = {vh, vl};
      m_upd = xfer_load && (nw != m_ang);
      if (xfer_load) m_ang = nw;
      m_hi = vh; m_lo = vl;
      bad = 0;
      for (int i = 0; i < 3; i++) begin
        if (i < 2) begin
          half = (i == 1) ? bus_data[15:8] : bus_data[7:0];
          if (half != pd[i]) quiet[i] = 0; else if (quiet[i] < BIG) quiet[i]++;
          pd[i] = half;
          if (en[i] && !pe[i] && quiet[i] < SETUP) bad = 1;   // R8
        end
        if (!en[i] && pe[i] && width[i] < PULSE) bad = 1;      // R9
        if (!en[i]) width[i] = 0; else if (width[i] < BIG) width[i]++;
        pe[i] = en[i];
      end
      if (bad) m_err = 1;                                      // R10
      o_upd = (bus_data != o_ang);
      o_ang = bus_data;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(angle_out == m_ang, {phase, " angle"}, 32'(angle_out), 32'(m_ang));
      check(angle_upd == m_upd, {phase, " R7 strobe"}, 32'(angle_upd), 32'(m_upd));
      check(timing_err == m_err, {phase, " error"}, 32'(timing_err), 32'(m_err));
      check(angle_o == o_ang && upd_o == o_upd && !err_o, "R6 open instance",
            {15'd0, upd_o, angle_o}, {15'd0, o_upd, o_ang});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(4); rst_n = 1'b1; step(1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    step(1);
    step(3); rst_n = 1'b1; step(1); rst_n = 1'b0; step(3);
    cmp_on = 1'b1;
    rst_n = 1'b1; step(2);
    check(angle_out == 16'h0 && !timing_err, "R1 reset state", 32'(angle_out), 0);

    // R2, R5: 8-bit style writes, same byte on both halves
    phase = "R2";
    bus_data = 16'h3C3C; step(20);
    hi_load = 1; step(30); hi_load = 0; step(2);
    bus_data = 16'h9696; step(20);
    lo_load = 1; step(30); lo_load = 0; step(3);
    check(angle_out == 16'h0000, "R5 bytes held back", 32'(angle_out), 0);
    phase = "R5";
    xfer_load = 1; step(30); xfer_load = 0; step(2);
    check(angle_out == 16'h3C96, "R2 byte placement", 32'(angle_out), 32'h3C96);

    // R3: bus changes with stages closed are ignored
    phase = "R3";
    bus_data = 16'hFFFF; step(5); bus_data = 16'h0101; step(20);
    xfer_load = 1; step(30); xfer_load = 0; step(2);
    check(angle_out == 16'h3C96, "R3 closed stages ignore bus", 32'(angle_out), 32'h3C96);

    // R4: all open, flow-through tracking
    phase = "R4";
    bus_data = 16'h1234; step(20);
    hi_load = 1; lo_load = 1; xfer_load = 1; step(2);
    check(angle_out == 16'h1234, "R4 flow-through", 32'(angle_out), 32'h1234);
    for (int k = 0; k < 6; k++) begin bus_data = 16'hA000 + 16'(k * 16'h0111); step(1); end
    step(25);
    hi_load = 0; lo_load = 0; xfer_load = 0; step(2);
    check(angle_out == 16'hA555, "R4 last tracked word", 32'(angle_out), 32'hA555);
    check(!timing_err, "R9 legal pulses", 32'(timing_err), 0);

    // R8: enable rises 3 cycles after a bus change
    phase = "R8";
    bus_data = 16'h7734; step(3);
    hi_load = 1; step(2);
    check(timing_err == 1'b1, "R8 setup violation", 32'(timing_err), 1);
    step(28); hi_load = 0;
    phase = "R10"; step(20);
    check(timing_err == 1'b1, "R10 sticky", 32'(timing_err), 1);
    do_reset();
    check(!timing_err && angle_out == 0, "R1 reset clears", 32'(timing_err), 0);

    // R9: short lower pulse, then short transfer pulse
    phase = "R9";
    bus_data = 16'h00C3; step(20);
    lo_load = 1; step(5); lo_load = 0; step(2);
    check(timing_err == 1'b1, "R9 short byte pulse", 32'(timing_err), 1);
    do_reset();
    xfer_load = 1; step(4); xfer_load = 0; step(2);
    check(timing_err == 1'b1, "R9 short transfer pulse", 32'(timing_err), 1);
    check(angle_out == 16'h0000 && !angle_upd, "R7 unchanged word no strobe", 32'(angle_out), 0);

    // R6: open instance follows bus with one edge delay
    phase = "R6";
    bus_data = 16'hBEEF; step(1);
    check(angle_o == 16'hBEEF, "R6 always open", 32'(angle_o), 32'hBEEF);
    step(5);
    summary();
  end
endmodule